// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Unit

This block arbitrates the interrupt lines of a small 8-bit processor core. There are five request lines. One line is non-maskable and can never be switched off. Three maskable lines branch to fixed restart addresses. The last maskable line takes its branch target from an external acknowledge cycle. Each line has its own trigger rule:

- The high vectored line latches a rising edge.
- The middle and low vectored lines, and the general external line, are plain levels that must still be high when sampled.
- The non-maskable line needs a rising edge, and the line must still be high when it is sampled.

The core pulses a sample strobe at each instruction boundary. At that strobe the unit takes the highest-priority eligible request. It then raises a request to the core, together with a 16-bit restart address and a flag that tells the core the target must come from the acknowledge cycle. The unit holds the request until the core reports that it has pushed the program counter and taken the branch.

The unit also holds the interrupt-enable flip-flop, with set and clear strobes. It holds a three-bit mask register that gates the vectored lines one by one. A write to the mask can also drop a captured edge on the high vectored line.

Top module: `irq_vector_unit`

## Requirements
- R1: When several requests are eligible at a sample strobe, the grant goes, highest priority first, to the non-maskable line (`nmi_in`), then `hi_in`, then `mid_in`, then `lo_in`, then `ext_in`.
- R2: The granted restart address is 0x0024 for `nmi_in`, 0x003C for `hi_in`, 0x0034 for `mid_in` and 0x002C for `lo_in`, and `ext_vec_o` is 0 for all of these. A grant to `ext_in` sets `ext_vec_o` to 1 and the address to 0x0000.
- R3: A rising edge on `hi_in` is captured and stays pending after the line falls, until a grant to it is completed by `done_i`. After that completion it does not fire again without a new edge.
- R4: `mid_in`, `lo_in` and `ext_in` are levels that are looked at only at a sample strobe. A pulse that has ended before the strobe is lost.
- R5: `nmi_in` is granted only when a rising edge has been seen and the line is still high at the sample strobe. A line held high after its grant does not fire again until it has gone low and risen again.
- R6: The enable flip-flop (`ie_o`) is 0 after reset. `ie_set_i` sets it and `ie_clr_i` clears it. Any grant clears it. Maskable lines are granted only while it is 1. `nmi_in` ignores both the enable flip-flop and the mask.
- R7: The mask register resets to 3'b111 and is loaded from `mask_data_i` when `mask_wr_i` is 1. Bit 2 gates `hi_in`, bit 1 gates `mid_in` and bit 0 gates `lo_in`, and a 1 blocks the line. A `hi_in` edge captured while that line is masked stays pending, and is granted once the line is unmasked.
- R8: A mask write with `hi_clr_i` = 1 drops a pending `hi_in` edge.
- R9: While `irq_req_o` is 1, the request, address and flag hold steady and further sample strobes are ignored. `irq_req_o` falls in the cycle after `done_i`.
- R10: `irq_req_o` rises only in the cycle right after a clock edge at which `sample_i` was 1. An eligible request without a strobe is not granted.
- R11: While and after reset, `irq_req_o` and `ie_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request line (edge and level) |
| hi_in | input | 1 | Highest maskable vectored line (edge latched) |
| mid_in | input | 1 | Middle maskable vectored line (level) |
| lo_in | input | 1 | Lowest maskable vectored line (level) |
| ext_in | input | 1 | General request line, externally vectored (level) |
| sample_i | input | 1 | Instruction-boundary sample strobe from the core |
| done_i | input | 1 | Core has pushed the program counter and branched |
| ie_set_i | input | 1 | Set the enable flip-flop |
| ie_clr_i | input | 1 | Clear the enable flip-flop |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 3 | New mask bits {hi, mid, lo}, 1 = blocked |
| hi_clr_i | input | 1 | With a mask write, drop the pending hi edge |
| irq_req_o | output | 1 | Interrupt request to the core |
| vector_o | output | 16 | Restart address of the granted line |
| ext_vec_o | output | 1 | Branch target comes from the acknowledge cycle |
| ie_o | output | 1 | Current state of the enable flip-flop |

## Verification
The bench goes after edge handling first:
- A short pulse on `hi_in` that is over before the strobe. A design with a level input there would lose it.
- A non-maskable pulse that falls before the strobe. A design with no level check would take a branch that should not happen.
- A non-maskable line held high after its grant. A design that never re-arms would fire on every boundary.

It also checks these cases:
- A `hi_in` edge that arrives while the line is masked must survive the unmask.
- A mask write carrying the clear bit must drop the edge, or a stale request would be taken later.
- A new non-maskable edge during an outstanding request. A design that re-arbitrates while busy would swap the address under the core. A design that loses the edge would never service it.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned NSRC   = 5;
    localparam int unsigned IDX_W  = $clog2(NSRC);
    localparam int unsigned MASK_W = 3;
    localparam int unsigned VEC_W  = 16;

    // index order is the fixed priority, 0 = highest
    typedef enum logic [IDX_W-1:0] {
        SRC_NMI = 3'd0,
        SRC_HI  = 3'd1,
        SRC_MID = 3'd2,
        SRC_LO  = 3'd3,
        SRC_EXT = 3'd4
    } src_e;

    localparam logic [VEC_W-1:0] ADDR_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] ADDR_HI  = 16'h003C;
    localparam logic [VEC_W-1:0] ADDR_MID = 16'h0034;
    localparam logic [VEC_W-1:0] ADDR_LO  = 16'h002C;

    typedef struct packed {
        logic             req;
        src_e             src;
        logic [VEC_W-1:0] vec;
        logic             ext;
    } grant_t;

    function automatic logic [VEC_W-1:0] restart_addr(src_e s);
        case (s)
            SRC_NMI: restart_addr = ADDR_NMI;
            SRC_HI:  restart_addr = ADDR_HI;
            SRC_MID: restart_addr = ADDR_MID;
            SRC_LO:  restart_addr = ADDR_LO;
            default: restart_addr = '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter bit NEED_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic drop;

    generate
        if (NEED_LEVEL) begin : g_level
            assign drop = clr_i | ~line_i;
        end else begin : g_latch
            assign drop = clr_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (line_i && !prev_q)
                pend_q <= 1'b1;
            else if (drop)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
    parameter int unsigned MW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ie_set_i,
    input  logic          ie_clr_i,
    input  logic          accept_i,
    input  logic          mask_wr_i,
    input  logic [MW-1:0] mask_data_i,
    output logic          ie_o,
    output logic [MW-1:0] mask_o
);
    logic          ie_q;
    logic [MW-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
        end else begin
            if (accept_i || ie_clr_i)
                ie_q <= 1'b0;
            else if (ie_set_i)
                ie_q <= 1'b1;
            if (mask_wr_i)
                mask_q <= mask_data_i;
        end
    end

    assign ie_o   = ie_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int unsigned N  = 5,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_in,
    input  logic              hi_in,
    input  logic              mid_in,
    input  logic              lo_in,
    input  logic              ext_in,
    input  logic              sample_i,
    input  logic              done_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_data_i,
    input  logic              hi_clr_i,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              ext_vec_o,
    output logic              ie_o
);
    grant_t            g_q;
    logic              nmi_pend, hi_pend;
    logic              nmi_clr, hi_clr;
    logic              ie;
    logic [MASK_W-1:0] mask;
    logic [NSRC-1:0]   cand;
    logic              any;
    logic [IDX_W-1:0]  win;
    logic              accept;
    logic              finish;

    assign finish  = g_q.req & done_i;
    assign nmi_clr = finish & (g_q.src == SRC_NMI);
    assign hi_clr  = (finish & (g_q.src == SRC_HI)) | (mask_wr_i & hi_clr_i);

    irq_edge_capture #(.NEED_LEVEL(1'b1)) u_nmi_edge (
        .clk(clk), .rst(rst), .line_i(nmi_in), .clr_i(nmi_clr), .pend_o(nmi_pend)
    );

    irq_edge_capture #(.NEED_LEVEL(1'b0)) u_hi_edge (
        .clk(clk), .rst(rst), .line_i(hi_in), .clr_i(hi_clr), .pend_o(hi_pend)
    );

    irq_ctrl_regs #(.MW(MASK_W)) u_regs (
        .clk(clk), .rst(rst),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .accept_i(accept),
        .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
        .ie_o(ie), .mask_o(mask)
    );

    always_comb begin
        cand          = '0;
        cand[SRC_NMI] = nmi_pend & nmi_in;
        cand[SRC_HI]  = ie & ~mask[2] & hi_pend;
        cand[SRC_MID] = ie & ~mask[1] & mid_in;
        cand[SRC_LO]  = ie & ~mask[0] & lo_in;
        cand[SRC_EXT] = ie & ext_in;
    end

    irq_arbiter #(.N(NSRC)) u_arb (
        .cand_i(cand), .any_o(any), .idx_o(win)
    );

    assign accept = sample_i & ~g_q.req & any;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else if (accept) begin
            g_q.req <= 1'b1;
            g_q.src <= src_e'(win);
            g_q.vec <= restart_addr(src_e'(win));
            g_q.ext <= (src_e'(win) == SRC_EXT);
        end else if (finish) begin
            g_q.req <= 1'b0;
        end
    end

    assign irq_req_o = g_q.req;
    assign vector_o  = g_q.vec;
    assign ext_vec_o = g_q.ext;
    assign ie_o      = ie;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        nmi_in,
    input logic        sample_i,
    input logic        done_i,
    input logic        irq_req_o,
    input logic [15:0] vector_o,
    input logic        ext_vec_o,
    input logic        ie_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        irq_req_o && !done_i |=> irq_req_o); // R9
    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
        irq_req_o && !done_i |=> $stable(vector_o) && $stable(ext_vec_o)); // R9
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
        irq_req_o && done_i |=> !irq_req_o); // R9
    AST_REQ_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req_o) |-> $past(sample_i)); // R10
    AST_IE_CLEARED_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req_o) |-> !ie_o); // R6
    AST_BLOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        sample_i && !irq_req_o && !ie_o && !nmi_in |=> !irq_req_o); // R6
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_req_o && !ext_vec_o |-> (vector_o == 16'h0024 || vector_o == 16'h003C ||
                                     vector_o == 16'h0034 || vector_o == 16'h002C)); // R2
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .sample_i(sample_i), .done_i(done_i),
    .irq_req_o(irq_req_o), .vector_o(vector_o), .ext_vec_o(ext_vec_o), .ie_o(ie_o)
);

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_in = 0, hi_in = 0, mid_in = 0, lo_in = 0, ext_in = 0;
    logic        sample_i = 0, done_i = 0, ie_set_i = 0, ie_clr_i = 0;
    logic        mask_wr_i = 0, hi_clr_i = 0;
    logic [2:0]  mask_data_i = 3'b000;
    logic        irq_req_o, ext_vec_o, ie_o;
    logic [15:0] vector_o;

    typedef struct {
        logic        req;
        logic [15:0] vec;
        logic        ext;
        logic        ie;
        string       tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    irq_vector_unit u_irq_vector_unit (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .hi_in(hi_in), .mid_in(mid_in),
        .lo_in(lo_in), .ext_in(ext_in), .sample_i(sample_i), .done_i(done_i),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .mask_wr_i(mask_wr_i),
        .mask_data_i(mask_data_i), .hi_clr_i(hi_clr_i), .irq_req_o(irq_req_o),
        .vector_o(vector_o), .ext_vec_o(ext_vec_o), .ie_o(ie_o)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_cmp++;
                if (irq_req_o !== it.req || ie_o !== it.ie ||
                    (it.req && (vector_o !== it.vec || ext_vec_o !== it.ext))) begin
                    n_bad++;
                    $display("FAIL %s: got req=%0b vec=%h ext=%0b ie=%0b, expected req=%0b vec=%h ext=%0b ie=%0b",
                             it.tag, irq_req_o, vector_o, ext_vec_o, ie_o,
                             it.req, it.vec, it.ext, it.ie);
                end
            end
        end
    end

    task automatic expect_now(logic r, logic [15:0] v, logic e, logic ie_exp, string tag);
        exp_t it;
        it.req = r; it.vec = v; it.ext = e; it.ie = ie_exp; it.tag = tag;
        q.push_back(it);
        ->chk_ev;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_sample(logic r, logic [15:0] v, logic e, logic ie_exp, string tag);
        sample_i = 1'b1;
        tick();
        sample_i = 1'b0;
        expect_now(r, v, e, ie_exp, tag);
    endtask

    task automatic serve(logic ie_exp, string tag);
        done_i = 1'b1;
        tick();
        done_i = 1'b0;
        expect_now(1'b0, 16'h0000, 1'b0, ie_exp, tag);
    endtask

    task automatic ie_on();
        ie_set_i = 1'b1;
        tick();
        ie_set_i = 1'b0;
    endtask

    task automatic mask_write(logic [2:0] m, logic clr);
        mask_wr_i = 1'b1; mask_data_i = m; hi_clr_i = clr;
        tick();
        mask_wr_i = 1'b0; hi_clr_i = 1'b0;
    endtask

    task automatic hi_pulse();
        hi_in = 1'b1; tick(); hi_in = 1'b0; tick();
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        expect_now(0, 0, 0, 0, "R11 during reset");
        rst = 1'b0;
        tick();
        expect_now(0, 0, 0, 0, "R11 after reset");

        // R6: maskable blocked after reset
        mask_write(3'b000, 0);
        mid_in = 1; do_sample(0, 0, 0, 0, "R6 enable clear after reset"); mid_in = 0;

        // R5/R6: non-maskable ignores enable
        nmi_in = 1; tick();
        do_sample(1, 16'h0024, 0, 0, "R5 nmi granted with enable off");
        serve(0, "R9 drop after done");
        do_sample(0, 0, 0, 0, "R5 held nmi does not refire");
        nmi_in = 0; tick();

        // R1/R2/R4 priority among levels
        ie_on();
        mid_in = 1; lo_in = 1; ext_in = 1;
        do_sample(1, 16'h0034, 0, 0, "R1 mid over lo and ext");
        serve(0, "R9 serve mid");
        ie_on();
        do_sample(1, 16'h0034, 0, 0, "R4 level still high regrants");
        serve(0, "R9 serve mid 2");
        mid_in = 0; ie_on();
        do_sample(1, 16'h002C, 0, 0, "R2 lo address");
        serve(0, "R9 serve lo");
        lo_in = 0; ie_on();
        do_sample(1, 16'h0000, 1, 0, "R2 ext flag");
        serve(0, "R9 serve ext");
        ext_in = 0;

        // R4 pulse lost
        ie_on();
        lo_in = 1; tick(); lo_in = 0;
        do_sample(0, 0, 0, 1, "R4 level pulse before strobe lost");

        // R7 mask bit 1 blocks mid
        mask_write(3'b010, 0);
        mid_in = 1; do_sample(0, 0, 0, 1, "R7 mid masked"); mid_in = 0;
        mask_write(3'b000, 0);

        // R3 hi edge latched
        hi_pulse();
        do_sample(1, 16'h003C, 0, 0, "R3 hi edge latched");
        serve(0, "R9 serve hi");
        ie_on();
        do_sample(0, 0, 0, 1, "R3 hi latch cleared by service");

        // R8 clear bit
        hi_pulse();
        mask_write(3'b000, 1);
        do_sample(0, 0, 0, 1, "R8 hi latch dropped by clear bit");

        // R7 masked edge survives unmask
        mask_write(3'b100, 0);
        hi_pulse();
        do_sample(0, 0, 0, 1, "R7 hi masked");
        mask_write(3'b000, 0);
        do_sample(1, 16'h003C, 0, 0, "R7 hi pending after unmask");
        serve(0, "R9 serve hi 2");

        // R5 nmi pulse gone before strobe
        nmi_in = 1; tick(); nmi_in = 0; tick();
        do_sample(0, 0, 0, 0, "R5 nmi low at strobe");

        // R1 nmi over hi
        ie_on();
        hi_pulse();
        nmi_in = 1; tick();
        do_sample(1, 16'h0024, 0, 0, "R1 nmi over hi");
        serve(0, "R9 serve nmi");
        ie_on();
        do_sample(1, 16'h003C, 0, 0, "R1 hi after nmi");
        serve(0, "R9 serve hi 3");
        nmi_in = 0; tick();

        // R9 busy ignores new strobes
        ie_on();
        mid_in = 1;
        do_sample(1, 16'h0034, 0, 0, "R9 mid granted");
        nmi_in = 1; tick();
        do_sample(1, 16'h0034, 0, 0, "R9 strobe ignored while busy");
        serve(0, "R9 serve busy mid");
        do_sample(1, 16'h0024, 0, 0, "R5 nmi edge kept across busy");
        serve(0, "R9 serve nmi 2");
        nmi_in = 0; mid_in = 0; tick();

        // R6 clear strobe
        ie_on();
        ie_clr_i = 1; tick(); ie_clr_i = 0;
        mid_in = 1;
        do_sample(0, 0, 0, 0, "R6 ie_clr blocks");
        mid_in = 0;

        // R10 no grant without strobe
        ie_on();
        mid_in = 1; tick();
        expect_now(0, 0, 0, 1, "R10 no grant without strobe");
        do_sample(1, 16'h0034, 0, 0, "R10 grant right after strobe");
        serve(0, "R9 serve final");
        mid_in = 0;
        tick();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule